// File: doc/BRIEF.md
# Reference-Counted Packet Buffer Manager

This block keeps the bookkeeping for a frame memory that is cut into fixed-size buffers. It never touches packet data. It hands out buffer indices from a free list, records for every buffer which buffer follows it in a packet, and keeps a per-buffer use count. A receive DMA builds a packet one buffer at a time. Each request can link the new buffer behind the one it allocated before. Later stages pass only the index of the first buffer along.

To send one packet out several times, each copy with its own header, a replicate command gives the number of copies N and the first buffer of the stored packet. The block allocates N fresh header buffers, one per cycle, and links each one in front of that first buffer. It also walks the existing chain and raises the count of every shared buffer by N-1. The payload stays in memory once. The transmit DMA releases each buffer it passes. A buffer whose count reaches zero goes back to the tail of the free list at once, with no software step.

The free-list size is reported. Space for a replicate is reserved when the command is accepted, so a replicate either yields all N headers or is rejected whole.

Top module: `pbm_buf_mgr`

## Requirements
- R1: After reset all NUM_BUFS buffers are free, queued in ascending index order. `free_count` equals NUM_BUFS and every response output and `underflow_err` is low.
- R2: An accepted allocation takes the oldest free index. In the next cycle `alloc_ok` pulses for one cycle with that index on `alloc_idx`. The new buffer has count 1 and no successor. When `alloc_link` is high, the buffer at `alloc_prev` gets the new buffer as its successor.
- R3: A request for an allocation when no unreserved buffer is free gives a one-cycle `alloc_fail` in the next cycle and allocates nothing. A replicate request that needs more buffers than are unreserved, or has N of 0 or more than REPL_MAX, gives a one-cycle `repl_fail` and allocates no header.
- R4: An accepted replicate of N copies delivers N header indices on `hdr_valid`/`hdr_idx`, at most one per cycle and in free-list order. Each header has count 1 and points to the given first buffer. Every buffer of the original chain gets N-1 added to its count, one buffer per cycle.
- R5: `repl_busy` is high from the cycle after acceptance until the last header has been issued and the last chain buffer updated. `repl_done` pulses in the cycle `repl_busy` falls. A replicate request while busy is rejected with `repl_fail`.
- R6: A release lowers the buffer's count by one. When the count reaches zero, the index is appended to the tail of the free list and `free_count` rises by one in the next cycle.
- R7: A release and an allocation in the same cycle are both served. An index freed in a cycle cannot be handed out in that same cycle. With an empty list the allocation fails and the index is available from the next cycle.
- R8: A receive allocation request takes precedence over header allocation: no header is issued in a cycle with `alloc_req` high. Buffers reserved for an accepted replicate are never handed to the receive side.
- R9: A release of a buffer whose count is zero (and that is not being raised in the same cycle) changes nothing and sets `underflow_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request one buffer for the receive side |
| alloc_link | input | 1 | Link the new buffer behind `alloc_prev` |
| alloc_prev | input | IDX_W | Buffer that gets the new one as successor |
| alloc_ok | output | 1 | Allocation granted (one cycle) |
| alloc_fail | output | 1 | Allocation refused, list empty (one cycle) |
| alloc_idx | output | IDX_W | Granted buffer index |
| repl_req | input | 1 | Replicate command |
| repl_head | input | IDX_W | First buffer of the stored packet |
| repl_n | input | N_W | Number of copies N |
| repl_busy | output | 1 | Replicate in progress |
| repl_fail | output | 1 | Replicate rejected (one cycle) |
| hdr_valid | output | 1 | A header buffer index is issued |
| hdr_idx | output | IDX_W | Issued header buffer index |
| repl_done | output | 1 | Replicate finished (one cycle) |
| rel_req | input | 1 | Transmit side releases one buffer |
| rel_idx | input | IDX_W | Buffer being released |
| free_count | output | CW | Number of buffers on the free list |
| underflow_err | output | 1 | Sticky count-underflow error |

## Verification
The same memory is driven with single-buffer and three-buffer chains. Matching indices show that free-list order and linking are kept apart. Replicates with N of 1 and 3 show whether shared buffers are held back by the right number of releases: a shared buffer must survive N-1 releases and free on the N-th. Exhaustion, release and allocation in one cycle on an empty list, a replicate accepted while the receive side keeps allocating, a second replicate while busy, and a release of a free buffer aim at the rejection, reuse-timing, precedence and underflow paths. A behavioural model compares every output on every clock.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    localparam int PBM_BUFS     = 16;
    localparam int PBM_CNT_W    = 4;
    localparam int PBM_REPL_MAX = 8;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/pbm_free_fifo.sv
module pbm_free_fifo #(
    parameter int NUM_BUFS = pbm_pkg::PBM_BUFS,
    localparam int IDX_W   = $clog2(NUM_BUFS),
    localparam int CW      = $clog2(NUM_BUFS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [CW-1:0]    count
);
    logic [IDX_W-1:0] mem [NUM_BUFS];
    logic [IDX_W-1:0] rd_ptr, wr_ptr;

    assign head_idx = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BUFS; i++) mem[i] <= IDX_W'(i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(NUM_BUFS);
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_idx;
                wr_ptr      <= IDX_W'(pbm_pkg::ring_next(int'(wr_ptr), NUM_BUFS));
            end
            if (pop) rd_ptr <= IDX_W'(pbm_pkg::ring_next(int'(rd_ptr), NUM_BUFS));
            count <= count + CW'(push) - CW'(pop);
        end
    end

    a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != CW'(NUM_BUFS)));

endmodule

// File: rtl/pbm_ref_table.sv
module pbm_ref_table #(
    parameter int NUM_BUFS = pbm_pkg::PBM_BUFS,
    parameter int CNT_W    = pbm_pkg::PBM_CNT_W,
    localparam int IDX_W   = $clog2(NUM_BUFS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             link_en,
    input  logic [IDX_W-1:0] link_prev,
    input  logic             hdr_en,
    input  logic [IDX_W-1:0] hdr_idx,
    input  logic [IDX_W-1:0] hdr_next,
    input  logic             walk_en,
    input  logic [IDX_W-1:0] walk_idx,
    input  logic [CNT_W-1:0] walk_add,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             walk_nv,
    output logic [IDX_W-1:0] walk_nxt,
    output logic             rel_free,
    output logic             rel_underflow
);
    logic [CNT_W-1:0] cnt_q [NUM_BUFS];
    logic [CNT_W-1:0] cnt_d [NUM_BUFS];
    logic [IDX_W-1:0] nxt_q [NUM_BUFS];
    logic [IDX_W-1:0] nxt_d [NUM_BUFS];
    logic [NUM_BUFS-1:0] nv_q, nv_d;

    logic [CNT_W-1:0] rel_cnt, rel_inc;

    assign walk_nv  = nv_q[walk_idx];
    assign walk_nxt = nxt_q[walk_idx];

    always_comb begin
        rel_cnt       = cnt_q[rel_idx];
        rel_inc       = (walk_en && walk_idx == rel_idx) ? walk_add : '0;
        rel_underflow = rel_en && (rel_cnt == '0) && (rel_inc == '0);
        rel_free      = rel_en && !rel_underflow && (rel_cnt + rel_inc == CNT_W'(1));
    end

    always_comb begin
        for (int i = 0; i < NUM_BUFS; i++) begin
            cnt_d[i] = cnt_q[i];
            nxt_d[i] = nxt_q[i];
            nv_d[i]  = nv_q[i];
            if (walk_en && walk_idx == IDX_W'(i))
                cnt_d[i] = cnt_d[i] + walk_add;
            if (rel_en && !rel_underflow && rel_idx == IDX_W'(i))
                cnt_d[i] = cnt_d[i] - CNT_W'(1);
            if (alloc_en && alloc_idx == IDX_W'(i)) begin
                cnt_d[i] = CNT_W'(1);
                nv_d[i]  = 1'b0;
            end
            if (link_en && link_prev == IDX_W'(i)) begin
                nxt_d[i] = alloc_idx;
                nv_d[i]  = 1'b1;
            end
            if (hdr_en && hdr_idx == IDX_W'(i)) begin
                cnt_d[i] = CNT_W'(1);
                nxt_d[i] = hdr_next;
                nv_d[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BUFS; i++) begin
                cnt_q[i] <= '0;
                nxt_q[i] <= '0;
            end
            nv_q <= '0;
        end else begin
            for (int i = 0; i < NUM_BUFS; i++) begin
                cnt_q[i] <= cnt_d[i];
                nxt_q[i] <= nxt_d[i];
            end
            nv_q <= nv_d;
        end
    end

    a_r2_link_needs_alloc: assert property (@(posedge clk) disable iff (rst)
        link_en |-> alloc_en);
    a_r8_one_pop_source: assert property (@(posedge clk) disable iff (rst)
        !(alloc_en && hdr_en));

endmodule

// File: rtl/pbm_repl_engine.sv
module pbm_repl_engine #(
    parameter int NUM_BUFS = pbm_pkg::PBM_BUFS,
    parameter int CNT_W    = pbm_pkg::PBM_CNT_W,
    parameter int REPL_MAX = pbm_pkg::PBM_REPL_MAX,
    localparam int IDX_W   = $clog2(NUM_BUFS),
    localparam int N_W     = $clog2(REPL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [IDX_W-1:0] head_in,
    input  logic [N_W-1:0]   n_in,
    input  logic             hdr_take,
    input  logic             walk_nv,
    input  logic [IDX_W-1:0] walk_nxt,
    output logic             busy,
    output logic             hdr_pending,
    output logic             walk_en,
    output logic [IDX_W-1:0] walk_idx,
    output logic [CNT_W-1:0] walk_add,
    output logic [IDX_W-1:0] head_reg,
    output logic             done
);
    import pbm_pkg::*;

    eng_state_e       st;
    logic [N_W-1:0]   hleft, hleft_n;
    logic             walking, walking_n;
    logic [IDX_W-1:0] cur;
    logic [CNT_W-1:0] add;

    assign busy        = (st == ENG_RUN);
    assign hdr_pending = (hleft != '0);
    assign walk_en     = busy && walking;
    assign walk_idx    = cur;
    assign walk_add    = add;

    always_comb begin
        hleft_n   = hleft - N_W'(hdr_take);
        walking_n = walking && walk_nv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_IDLE;
            hleft    <= '0;
            walking  <= 1'b0;
            cur      <= '0;
            add      <= '0;
            head_reg <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    if (accept) begin
                        st       <= ENG_RUN;
                        hleft    <= n_in;
                        walking  <= 1'b1;
                        cur      <= head_in;
                        add      <= CNT_W'(n_in - N_W'(1));
                        head_reg <= head_in;
                    end
                end
                ENG_RUN: begin
                    hleft   <= hleft_n;
                    walking <= walking_n;
                    if (walking_n) cur <= walk_nxt;
                    if (hleft_n == '0 && !walking_n) begin
                        st   <= ENG_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    a_r5_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        accept |-> !busy);
    a_r4_take_needs_pending: assert property (@(posedge clk) disable iff (rst)
        hdr_take |-> (busy && hdr_pending));

endmodule

// File: rtl/pbm_buf_mgr.sv
module pbm_buf_mgr #(
    parameter int NUM_BUFS = pbm_pkg::PBM_BUFS,
    parameter int CNT_W    = pbm_pkg::PBM_CNT_W,
    parameter int REPL_MAX = pbm_pkg::PBM_REPL_MAX,
    localparam int IDX_W   = $clog2(NUM_BUFS),
    localparam int CW      = $clog2(NUM_BUFS + 1),
    localparam int N_W     = $clog2(REPL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic             alloc_link,
    input  logic [IDX_W-1:0] alloc_prev,
    output logic             alloc_ok,
    output logic             alloc_fail,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             repl_req,
    input  logic [IDX_W-1:0] repl_head,
    input  logic [N_W-1:0]   repl_n,
    output logic             repl_busy,
    output logic             repl_fail,
    output logic             hdr_valid,
    output logic [IDX_W-1:0] hdr_idx,
    output logic             repl_done,
    input  logic             rel_req,
    input  logic [IDX_W-1:0] rel_idx,
    output logic [CW-1:0]    free_count,
    output logic             underflow_err
);
    logic [IDX_W-1:0] head_idx;
    logic [CW-1:0]    reserved, avail, avail_left;
    logic             alloc_take, hdr_take, pop, n_ok, repl_accept;
    logic             hdr_pending, walk_en, walk_nv, rel_free, rel_underflow;
    logic [IDX_W-1:0] walk_idx, walk_nxt, head_reg;
    logic [CNT_W-1:0] walk_add;

    always_comb begin
        avail       = free_count - reserved;
        alloc_take  = alloc_req && (avail != '0);
        avail_left  = avail - CW'(alloc_take);
        n_ok        = (repl_n != '0) && (int'(repl_n) <= REPL_MAX);
        repl_accept = repl_req && !repl_busy && n_ok && (avail_left >= CW'(repl_n));
        hdr_take    = repl_busy && hdr_pending && !alloc_req;
        pop         = alloc_take || hdr_take;
    end

    pbm_free_fifo #(.NUM_BUFS(NUM_BUFS)) u_free (
        .clk      (clk),
        .rst      (rst),
        .pop      (pop),
        .push     (rel_free),
        .push_idx (rel_idx),
        .head_idx (head_idx),
        .count    (free_count)
    );

    pbm_ref_table #(.NUM_BUFS(NUM_BUFS), .CNT_W(CNT_W)) u_refs (
        .clk           (clk),
        .rst           (rst),
        .alloc_en      (alloc_take),
        .alloc_idx     (head_idx),
        .link_en       (alloc_take && alloc_link),
        .link_prev     (alloc_prev),
        .hdr_en        (hdr_take),
        .hdr_idx       (head_idx),
        .hdr_next      (head_reg),
        .walk_en       (walk_en),
        .walk_idx      (walk_idx),
        .walk_add      (walk_add),
        .rel_en        (rel_req),
        .rel_idx       (rel_idx),
        .walk_nv       (walk_nv),
        .walk_nxt      (walk_nxt),
        .rel_free      (rel_free),
        .rel_underflow (rel_underflow)
    );

    pbm_repl_engine #(.NUM_BUFS(NUM_BUFS), .CNT_W(CNT_W), .REPL_MAX(REPL_MAX)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .accept      (repl_accept),
        .head_in     (repl_head),
        .n_in        (repl_n),
        .hdr_take    (hdr_take),
        .walk_nv     (walk_nv),
        .walk_nxt    (walk_nxt),
        .busy        (repl_busy),
        .hdr_pending (hdr_pending),
        .walk_en     (walk_en),
        .walk_idx    (walk_idx),
        .walk_add    (walk_add),
        .head_reg    (head_reg),
        .done        (repl_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_ok      <= 1'b0;
            alloc_fail    <= 1'b0;
            alloc_idx     <= '0;
            hdr_valid     <= 1'b0;
            hdr_idx       <= '0;
            repl_fail     <= 1'b0;
            reserved      <= '0;
            underflow_err <= 1'b0;
        end else begin
            alloc_ok   <= alloc_take;
            alloc_fail <= alloc_req && !alloc_take;
            alloc_idx  <= head_idx;
            hdr_valid  <= hdr_take;
            hdr_idx    <= head_idx;
            repl_fail  <= repl_req && !repl_accept;
            reserved   <= reserved + (repl_accept ? CW'(repl_n) : '0) - CW'(hdr_take);
            if (rel_underflow) underflow_err <= 1'b1;
        end
    end

    a_r2_ok_fail_excl: assert property (@(posedge clk) disable iff (rst)
        !(alloc_ok && alloc_fail));
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        repl_done |-> !repl_busy);
    a_r4_hdr_from_busy: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> $past(repl_busy));
    a_r8_hdr_yields: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> !$past(alloc_req));
    a_r8_reserve_bounded: assert property (@(posedge clk) disable iff (rst)
        reserved <= free_count);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow_err |=> underflow_err);

endmodule

// File: tb/pbm_buf_mgr_tb.sv
`timescale 1ns/1ps
module pbm_buf_mgr_tb;
    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_req = 0, alloc_link = 0, repl_req = 0, rel_req = 0;
    logic [3:0] alloc_prev = '0, repl_head = '0, rel_idx = '0, repl_n = '0;
    logic       alloc_ok, alloc_fail, repl_busy, repl_fail, hdr_valid, repl_done, underflow_err;
    logic [3:0] alloc_idx, hdr_idx;
    logic [4:0] free_count;

    always #2.5 clk = ~clk;

    pbm_buf_mgr u_dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_link(alloc_link), .alloc_prev(alloc_prev),
        .alloc_ok(alloc_ok), .alloc_fail(alloc_fail), .alloc_idx(alloc_idx),
        .repl_req(repl_req), .repl_head(repl_head), .repl_n(repl_n),
        .repl_busy(repl_busy), .repl_fail(repl_fail), .hdr_valid(hdr_valid),
        .hdr_idx(hdr_idx), .repl_done(repl_done),
        .rel_req(rel_req), .rel_idx(rel_idx),
        .free_count(free_count), .underflow_err(underflow_err)
    );

    int n_checks = 0, n_errs = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt[NB], m_nxt[NB];
    bit m_nv[NB];
    int free_q[$], walk_q[$];
    int m_res, m_hleft, m_add, m_hnext;
    bit m_busy, m_uf;
    bit e_aok, e_afail, e_hv, e_rfail, e_done;
    int e_aidx, e_hidx;

    always @(posedge clk) begin
        if (rst) begin
            free_q.delete(); walk_q.delete();
            for (int i = 0; i < NB; i++) begin
                free_q.push_back(i); m_cnt[i] = 0; m_nxt[i] = 0; m_nv[i] = 0;
            end
            m_res = 0; m_hleft = 0; m_add = 0; m_hnext = 0; m_busy = 0; m_uf = 0;
            e_aok = 0; e_afail = 0; e_hv = 0; e_rfail = 0; e_done = 0; e_aidx = 0; e_hidx = 0;
        end else begin
            int avail, head, w, rc, rinc;
            bit a_take, acc, h_take, wen, rfree, ufl;
            avail  = free_q.size() - m_res;
            head   = (free_q.size() > 0) ? free_q[0] : 0;
            a_take = alloc_req && avail > 0;
            acc    = repl_req && !m_busy && repl_n >= 1 && repl_n <= 8 &&
                     (avail - int'(a_take)) >= int'(repl_n);
            h_take = m_busy && m_hleft > 0 && !alloc_req;
            wen    = m_busy && walk_q.size() > 0;
            w      = wen ? walk_q[0] : -1;
            rfree  = 0; ufl = 0;
            if (rel_req) begin
                rc   = m_cnt[rel_idx];
                rinc = (wen && w == int'(rel_idx)) ? m_add : 0;
                if (rc == 0 && rinc == 0) begin ufl = 1; m_uf = 1; end
                else if (rc + rinc == 1) rfree = 1;
            end
            if (wen) begin m_cnt[w] += m_add; void'(walk_q.pop_front()); end
            if (rel_req && !ufl) m_cnt[rel_idx] -= 1;
            e_aok = a_take; e_afail = alloc_req && !a_take; e_aidx = head;
            e_hv = h_take; e_hidx = head; e_rfail = repl_req && !acc; e_done = 0;
            if (a_take) begin
                void'(free_q.pop_front());
                m_cnt[head] = 1; m_nv[head] = 0;
                if (alloc_link) begin m_nxt[alloc_prev] = head; m_nv[alloc_prev] = 1; end
            end
            if (h_take) begin
                void'(free_q.pop_front());
                m_cnt[head] = 1; m_nxt[head] = m_hnext; m_nv[head] = 1;
                m_hleft--; m_res--;
            end
            if (rfree) free_q.push_back(rel_idx);
            if (acc) begin
                int p;
                m_busy = 1; m_hleft = repl_n; m_add = repl_n - 1;
                m_res += repl_n; m_hnext = repl_head;
                p = repl_head;
                for (int k = 0; k < NB; k++) begin
                    walk_q.push_back(p);
                    if (!m_nv[p]) break;
                    p = m_nxt[p];
                end
            end else if (m_busy && m_hleft == 0 && walk_q.size() == 0) begin
                m_busy = 0; e_done = 1;
            end
        end
    end

    // per-clock comparison and capture
    int got_alloc[$], got_hdr[$];
    int af_cnt = 0, rf_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(alloc_ok == e_aok, "R2", "alloc_ok", alloc_ok, e_aok);
            if (e_aok) chk(int'(alloc_idx) == e_aidx, "R2", "alloc_idx", alloc_idx, e_aidx);
            chk(alloc_fail == e_afail, "R3", "alloc_fail", alloc_fail, e_afail);
            chk(hdr_valid == e_hv, "R4", "hdr_valid", hdr_valid, e_hv);
            if (e_hv) chk(int'(hdr_idx) == e_hidx, "R4", "hdr_idx", hdr_idx, e_hidx);
            chk(repl_fail == e_rfail, "R5", "repl_fail", repl_fail, e_rfail);
            chk(repl_done == e_done, "R5", "repl_done", repl_done, e_done);
            chk(repl_busy == m_busy, "R5", "repl_busy", repl_busy, m_busy);
            chk(int'(free_count) == free_q.size(), "R6", "free_count", free_count, free_q.size());
            chk(underflow_err == m_uf, "R9", "underflow_err", underflow_err, m_uf);
            if (alloc_ok) got_alloc.push_back(alloc_idx);
            if (hdr_valid) got_hdr.push_back(hdr_idx);
            if (alloc_fail) af_cnt++;
            if (repl_fail) rf_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    task automatic clear_all();
        alloc_req = 0; alloc_link = 0; repl_req = 0; rel_req = 0;
    endtask

    task automatic op(input bit a, input bit lk, input int prev, input bit r, input int ridx,
                      input bit p, input int ph, input int pn);
        @(negedge clk);
        clear_all();
        alloc_req = a; alloc_link = lk; alloc_prev = 4'(prev);
        rel_req = r; rel_idx = 4'(ridx);
        repl_req = p; repl_head = 4'(ph); repl_n = 4'(pn);
    endtask

    task automatic settle(input int n);
        repeat (n) begin @(negedge clk); clear_all(); end
        #1;
    endtask

    task automatic rel(input int idx);
        op(0, 0, 0, 1, idx, 0, 0, 0);
    endtask

    initial begin
        int k0;
        clear_all();
        repeat (3) @(negedge clk);
        rst = 0;
        settle(1);
        chk(free_count == 5'd16, "R1", "free_count after reset", free_count, 16);
        chk(!alloc_ok && !hdr_valid && !underflow_err && !repl_busy, "R1", "idle outputs", 0, 0);

        // three-buffer chain 0 -> 1 -> 2
        op(1, 0, 0, 0, 0, 0, 0, 0); settle(1);
        chk(got_alloc[$] == 0, "R2", "first index", got_alloc[$], 0);
        op(1, 1, 0, 0, 0, 0, 0, 0); settle(1);
        op(1, 1, 1, 0, 0, 0, 0, 0); settle(1);
        chk(got_alloc[$] == 2, "R2", "third index", got_alloc[$], 2);
        chk(free_count == 5'd13, "R2", "free after chain", free_count, 13);
        rel(0); rel(1); rel(2); settle(1);
        chk(free_count == 5'd16, "R6", "all released", free_count, 16);

        // chain 3 -> 4, replicate three ways, second request while busy
        op(1, 0, 0, 0, 0, 0, 0, 0);
        op(1, 1, 3, 0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 1, 3, 3);
        op(0, 0, 0, 0, 0, 1, 3, 1);
        settle(6);
        chk(rf_cnt == 1, "R5", "busy rejects replicate", rf_cnt, 1);
        chk(got_hdr.size() == 3 && got_hdr[0] == 5 && got_hdr[2] == 7, "R4", "headers 5..7",
            got_hdr.size() > 2 ? got_hdr[2] : -1, 7);
        chk(free_count == 5'd11, "R4", "free after replicate", free_count, 11);
        rel(5); rel(6); rel(7); rel(3); rel(3); settle(1);
        chk(free_count == 5'd14, "R4", "shared buffer held", free_count, 14);
        rel(3); settle(1);
        chk(free_count == 5'd15, "R4", "shared freed on last copy", free_count, 15);
        rel(4); rel(4); rel(4); settle(1);
        chk(free_count == 5'd16, "R6", "replicate fully released", free_count, 16);

        // single-copy replicate of a one-buffer packet
        op(1, 0, 0, 0, 0, 0, 0, 0); settle(1);
        k0 = got_alloc[$];
        op(0, 0, 0, 0, 0, 1, k0, 1); settle(3);
        rel(k0); rel(got_hdr[$]); settle(1);
        chk(free_count == 5'd16, "R4", "n=1 leaves count", free_count, 16);

        // receive allocation during replicate delays headers
        op(1, 0, 0, 0, 0, 0, 0, 0); settle(1);
        k0 = got_alloc[$];
        op(0, 0, 0, 0, 0, 1, k0, 2);
        op(1, 0, 0, 0, 0, 0, 0, 0);
        op(1, 0, 0, 0, 0, 0, 0, 0);
        settle(1);
        chk(repl_busy == 1'b1, "R8", "headers wait for receive", repl_busy, 1);
        settle(4);
        chk(free_count == 5'd11, "R8", "free after mixed", free_count, 11);
        for (int i = 0; i < 5; i++) begin
            if (got_alloc.size() > 0 && i < 3) rel(got_alloc[got_alloc.size() - 1 - i]);
        end
        rel(got_hdr[$]); rel(got_hdr[got_hdr.size() - 2]); rel(k0); settle(1);
        chk(free_count == 5'd16, "R6", "mixed released", free_count, 16);

        // exhaustion
        got_alloc.delete();
        for (int i = 0; i < 16; i++) op(1, 0, 0, 0, 0, 0, 0, 0);
        settle(1);
        chk(free_count == 5'd0, "R3", "list empty", free_count, 0);
        op(1, 0, 0, 0, 0, 0, 0, 0); settle(1);
        chk(alloc_fail == 1'b1 && af_cnt == 1, "R3", "alloc on empty", af_cnt, 1);
        op(0, 0, 0, 0, 0, 1, got_alloc[0], 1); settle(1);
        chk(repl_fail == 1'b1 && free_count == 5'd0, "R3", "replicate on empty", free_count, 0);

        // release and allocate in the same cycle on an empty list
        k0 = got_alloc[0];
        op(1, 0, 0, 1, k0, 0, 0, 0); settle(1);
        chk(alloc_fail == 1'b1 && free_count == 5'd1, "R7", "freed index not same cycle", free_count, 1);
        op(1, 0, 0, 0, 0, 0, 0, 0); settle(1);
        chk(alloc_ok == 1'b1 && int'(alloc_idx) == k0, "R7", "freed index next cycle", alloc_idx, k0);
        for (int i = 0; i < 16; i++) rel(got_alloc[i]);
        settle(1);
        chk(free_count == 5'd16, "R6", "restored", free_count, 16);

        // underflow
        rel(k0); settle(1);
        chk(underflow_err == 1'b1 && free_count == 5'd16, "R9", "underflow flagged", underflow_err, 1);
        settle(3);
        chk(underflow_err == 1'b1, "R9", "underflow sticky", underflow_err, 1);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule